// File: doc/BRIEF.md
# Paged Effective Address Sequencer

This block works out the operand address of a memory-reference instruction for a 12-bit accumulator machine. Every address is either a word in page zero or a word in the page that holds the current instruction. It can also go through one level of indirection, where the word at that address is fetched and used as the final address. A caller presents the instruction word and the address of that instruction (sampled before the program counter moves on), pulses `start_i`, and waits for `done_o`. At that point `ea_o` holds the effective address.

A direct reference finishes one cycle after start and touches no memory. An indirect reference reads the pointer word through a simple request/ready memory port. If the pointer sits in the reserved auto-increment window (absolute addresses 8 to 15 by default), the block adds one to it modulo the address space and writes the new value back to the same word. That incremented value becomes the effective address. Opcode execution, instruction fetch and bank extension belong to other blocks.

Top module: `paged_ea_seq`

## Requirements
- R1: With instruction bit 7 (page flag) at 0 and bit 8 (indirect flag) at 0, `ea_o` equals the offset in bits [6:0], with the upper 5 bits zero.
- R2: With page flag 1 and indirect flag 0, `ea_o` is `pc_i[11:7]` concatenated with the offset in bits [6:0].
- R3: A direct reference raises `done_o` in the cycle after start and issues no memory request. Bits [11:9] (opcode) have no effect on the result.
- R4: An indirect reference whose pointer address lies outside the window makes exactly one read, at the page-formed address, and no write. `ea_o` equals the word read.
- R5: An indirect reference whose pointer address lies in 8..15 reads the pointer and then writes pointer+1 (mod 4096) to the same address. `ea_o` equals pointer+1.
- R6: Addresses just outside the window (7, 16) and current-page addresses whose low bits fall in 8..15 get no write-back.
- R7: A memory request keeps its address and direction until `mem_ready_i` is high. Each stall cycle lengthens the operation by one cycle: an indirect reference takes 2+L cycles and an auto-increment reference takes 3+2L cycles, where L is the stall count per access.
- R8: A start that arrives while `busy_o` is high is ignored.
- R9: `done_o` is a single-cycle pulse. `ea_o` stays unchanged from done until the next accepted start.
- R10: Synchronous active-high reset, even in the middle of an operation, returns the block to idle with `done_o`, `busy_o` and `mem_req_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin address resolution (accepted only when idle) |
| instr_i | input | 12 | Instruction word |
| pc_i | input | 12 | Address of the instruction being decoded |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 12 | Memory word address |
| mem_wdata_o | output | 12 | Write data |
| mem_rdata_i | input | 12 | Read data, valid while ready is high |
| mem_ready_i | input | 1 | Access completes in this cycle |
| ea_o | output | 12 | Effective address |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Operation in progress |

## Verification
The bench builds the block with its default parameters: 12-bit words, 7-bit page offsets and an auto-increment window of eight words based at address 8. This puts both window edges (7/8 and 15/16) and the wrap of the pointer from 4095 to 0 within easy reach of directed tests. The bench's memory model inserts a stall count that is set at run time, from zero to several cycles. The same instructions are therefore checked for cycle counts under both immediate and delayed ready.

// File: rtl/pea_pkg.sv
package pea_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } pea_state_e;

    typedef struct packed {
        logic req;
        logic we;
    } mem_ctl_t;

    function automatic mem_ctl_t ctl_of(input pea_state_e st);
        mem_ctl_t c;
        c.req = (st != ST_IDLE);
        c.we  = (st == ST_WRITE);
        return c;
    endfunction

endpackage

// File: rtl/pea_addr_form.sv
module pea_addr_form #(
    parameter int W     = 12,
    parameter int OFF_W = 7
) (
    input  logic [OFF_W+1:0]   ins_low_i,
    input  logic [W-1:OFF_W]   pc_page_i,
    output logic [W-1:0]       addr_o,
    output logic               indirect_o
);
    localparam int PAGE_W = W - OFF_W;

    logic cur_page;
    assign cur_page   = ins_low_i[OFF_W];
    assign indirect_o = ins_low_i[OFF_W+1];

    always_comb begin
        if (cur_page)
            addr_o = {pc_page_i, ins_low_i[OFF_W-1:0]};
        else
            addr_o = {{PAGE_W{1'b0}}, ins_low_i[OFF_W-1:0]};
    end
endmodule

// File: rtl/pea_auto_win.sv
module pea_auto_win #(
    parameter int W  = 12,
    parameter int LO = 8,
    parameter int N  = 8
) (
    input  logic [W-1:0] addr_i,
    output logic         hit_o
);
    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W:0]   HI_V = (W+1)'(LO + N);

    assign hit_o = (addr_i >= LO_V) && ({1'b0, addr_i} < HI_V);
endmodule

// File: rtl/pea_seq.sv
module pea_seq
    import pea_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         indirect_i,
    input  logic [W-1:0] form_addr_i,
    input  logic         auto_hit_i,
    input  logic         mem_ready_i,
    input  logic [W-1:0] mem_rdata_i,
    output logic         mem_req_o,
    output logic         mem_we_o,
    output logic [W-1:0] mem_addr_o,
    output logic [W-1:0] mem_wdata_o,
    output logic [W-1:0] ea_o,
    output logic         done_o,
    output logic         busy_o
);
    pea_state_e   state;
    logic [W-1:0] ptr_q;
    logic [W-1:0] ea_q;
    logic         auto_q;
    logic         done_q;
    mem_ctl_t     ctl;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ptr_q  <= '0;
            ea_q   <= '0;
            auto_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        if (indirect_i) begin
                            ptr_q  <= form_addr_i;
                            auto_q <= auto_hit_i;
                            state  <= ST_READ;
                        end else begin
                            ea_q   <= form_addr_i;
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ready_i) begin
                        if (auto_q) begin
                            ea_q  <= mem_rdata_i + W'(1);
                            state <= ST_WRITE;
                        end else begin
                            ea_q   <= mem_rdata_i;
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (mem_ready_i) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ctl         = ctl_of(state);
    assign mem_req_o   = ctl.req;
    assign mem_we_o    = ctl.we;
    assign mem_addr_o  = ptr_q;
    assign mem_wdata_o = ea_q;
    assign ea_o        = ea_q;
    assign done_o      = done_q;
    assign busy_o      = (state != ST_IDLE);
endmodule

// File: rtl/paged_ea_seq.sv
module paged_ea_seq #(
    parameter int W       = 12,
    parameter int OFF_W   = 7,
    parameter int AUTO_LO = 8,
    parameter int AUTO_N  = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] instr_i,
    input  logic [W-1:0] pc_i,
    output logic         mem_req_o,
    output logic         mem_we_o,
    output logic [W-1:0] mem_addr_o,
    output logic [W-1:0] mem_wdata_o,
    input  logic [W-1:0] mem_rdata_i,
    input  logic         mem_ready_i,
    output logic [W-1:0] ea_o,
    output logic         done_o,
    output logic         busy_o
);
    logic [W-1:0] form_addr;
    logic         indirect;
    logic         auto_hit;

    // Opcode and in-page PC bits do not take part in address formation.
    logic unused_bits;
    assign unused_bits = ^{instr_i[W-1:OFF_W+2], pc_i[OFF_W-1:0]};

    pea_addr_form #(.W(W), .OFF_W(OFF_W)) u_form (
        .ins_low_i  (instr_i[OFF_W+1:0]),
        .pc_page_i  (pc_i[W-1:OFF_W]),
        .addr_o     (form_addr),
        .indirect_o (indirect)
    );

    pea_auto_win #(.W(W), .LO(AUTO_LO), .N(AUTO_N)) u_win (
        .addr_i (form_addr),
        .hit_o  (auto_hit)
    );

    pea_seq #(.W(W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .indirect_i  (indirect),
        .form_addr_i (form_addr),
        .auto_hit_i  (auto_hit),
        .mem_ready_i (mem_ready_i),
        .mem_rdata_i (mem_rdata_i),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .ea_o        (ea_o),
        .done_o      (done_o),
        .busy_o      (busy_o)
    );
endmodule

// File: rtl/pea_checker.sv
module pea_checker #(
    parameter int W  = 12,
    parameter int LO = 8,
    parameter int N  = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         mem_req_o,
    input logic         mem_we_o,
    input logic [W-1:0] mem_addr_o,
    input logic         mem_ready_i,
    input logic [W-1:0] ea_o,
    input logic         done_o,
    input logic         busy_o
);
    // R7: an unanswered request keeps address and direction
    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    // R5: a write only begins directly after a completed read
    p_write_follows_read_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_o) |-> $past(mem_req_o && !mem_we_o && mem_ready_i));

    // R6: write-back only targets the auto-increment window
    p_write_in_window_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> ((int'(mem_addr_o) >= LO) && (int'(mem_addr_o) < LO + N)));

    // R9: completion is reported only once the block is idle
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R9: effective address holds while idle without a start
    p_ea_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(ea_o));

    // R10: reset leaves the block idle
    p_reset_idle_r10: assert property (@(posedge clk)
        rst |=> (!done_o && !busy_o && !mem_req_o));
endmodule

bind paged_ea_seq pea_checker #(.W(W), .LO(AUTO_LO), .N(AUTO_N)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ready_i (mem_ready_i),
    .ea_o        (ea_o),
    .done_o      (done_o),
    .busy_o      (busy_o)
);

// File: tb/paged_ea_seq_bench.sv
module paged_ea_seq_bench;
    localparam int W      = 12;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] instr = '0;
    logic [W-1:0] pc_in = '0;
    logic         mem_req, mem_we, mem_ready;
    logic [W-1:0] mem_addr, mem_wdata, mem_rdata;
    logic [W-1:0] ea;
    logic         done, busy;

    int ntest = 0;
    int nfail = 0;
    int lat   = 0;
    int cnt   = 0;
    int nrd   = 0;
    int nwr   = 0;
    bit finished = 0;

    logic         poke_en = 1'b0;
    logic [W-1:0] poke_addr = '0;
    logic [W-1:0] poke_data = '0;
    logic [W-1:0] mem [0:(1<<W)-1];

    always #(PERIOD/2) clk = ~clk;

    paged_ea_seq u_paged_ea_seq (
        .clk(clk), .rst(rst), .start_i(start), .instr_i(instr), .pc_i(pc_in),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
        .ea_o(ea), .done_o(done), .busy_o(busy)
    );

    // Memory model with programmable stall count per access
    assign mem_ready = mem_req && (cnt >= lat);
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (poke_en) mem[poke_addr] <= poke_data;
        if (mem_req && !mem_ready) cnt <= cnt + 1;
        else cnt <= 0;
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                nwr <= nwr + 1;
            end else begin
                nrd <= nrd + 1;
            end
        end
    end

    function automatic logic [W-1:0] mk(input logic [2:0] op, input logic ind,
                                        input logic pg, input logic [6:0] off);
        return {op, ind, pg, off};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        ntest++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [W-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    // One reference; checks address, cycle count, reads, writes, single pulse
    task automatic run_ref(input string tag, input logic [W-1:0] ins, input logic [W-1:0] pc,
                           input logic [W-1:0] exp_ea, input int exp_rd, input int exp_wr,
                           input int exp_cyc);
        int rd0, wr0, cyc;
        @(negedge clk);
        rd0 = nrd; wr0 = nwr;
        instr = ins; pc_in = pc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        chk({tag, " done"}, done, 1);
        chk({tag, " ea"}, ea, exp_ea);
        chk({tag, " cycles"}, cyc, exp_cyc);
        chk({tag, " reads"}, nrd - rd0, exp_rd);
        chk({tag, " writes"}, nwr - wr0, exp_wr);
        @(negedge clk);
        chk({tag, " R9 done pulse"}, done, 0);
    endtask

    task automatic t_reset;
        chk("R10 reset done", done, 0);
        chk("R10 reset busy", busy, 0);
        chk("R10 reset req", mem_req, 0);
    endtask

    task automatic t_direct;
        lat = 0;
        run_ref("R1 page zero", mk(3'd1, 0, 0, 7'h53), 12'hA85, 12'h053, 0, 0, 1);
        run_ref("R2 current page", mk(3'd2, 0, 1, 7'h53), 12'hA85, {5'(12'hA85 >> 7), 7'h53}, 0, 0, 1);
        lat = 3;
        run_ref("R3 opcode ignored", mk(3'd7, 0, 1, 7'h7F), 12'hFFF, 12'hFFF, 0, 0, 1);
    endtask

    task automatic t_indirect;
        poke(12'h020, 12'h7FF);
        lat = 0;
        run_ref("R4 plain indirect", mk(3'd0, 1, 0, 7'h20), 12'h000, 12'h7FF, 1, 0, 2);
        lat = 3;
        run_ref("R7 indirect stall", mk(3'd0, 1, 0, 7'h20), 12'h000, 12'h7FF, 1, 0, 5);
    endtask

    task automatic t_auto;
        poke(12'h008, 12'h123);
        poke(12'h00F, 12'hFFF);
        lat = 0;
        run_ref("R5 auto low edge", mk(3'd1, 1, 0, 7'h08), 12'h000, 12'h124, 1, 1, 3);
        chk("R5 writeback 8", mem[12'h008], 12'h124);
        lat = 2;
        run_ref("R5 auto wrap", mk(3'd1, 1, 0, 7'h0F), 12'h000, 12'h000, 1, 1, 7);
        chk("R5 writeback 15", mem[12'h00F], 12'h000);
    endtask

    task automatic t_outside;
        poke(12'h007, 12'h0A1);
        poke(12'h010, 12'h0A2);
        poke(12'h408, 12'h0AB);
        lat = 0;
        run_ref("R6 addr 7", mk(3'd1, 1, 0, 7'h07), 12'h000, 12'h0A1, 1, 0, 2);
        chk("R6 mem 7 kept", mem[12'h007], 12'h0A1);
        run_ref("R6 addr 16", mk(3'd1, 1, 0, 7'h10), 12'h000, 12'h0A2, 1, 0, 2);
        chk("R6 mem 16 kept", mem[12'h010], 12'h0A2);
        run_ref("R6 current page 8", mk(3'd1, 1, 1, 7'h08), 12'h400, 12'h0AB, 1, 0, 2);
        chk("R6 mem 408 kept", mem[12'h408], 12'h0AB);
    endtask

    task automatic t_busy_ignore;
        int pulses, cyc, rd0;
        poke(12'h030, 12'h555);
        lat = 4;
        @(negedge clk);
        rd0 = nrd;
        instr = mk(3'd0, 1, 0, 7'h30); pc_in = '0; start = 1'b1;
        @(negedge clk);
        instr = mk(3'd0, 0, 0, 7'h7F); start = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        pulses = 0;
        for (int i = 0; i < 12; i++) begin
            if (done) pulses++;
            @(negedge clk);
        end
        chk("R8 one done", pulses, 1);
        chk("R8 ea first ref", ea, 12'h555);
        chk("R8 one read", nrd - rd0, 1);
        // R9: ea stays while inputs move without start
        instr = mk(3'd0, 0, 0, 7'h11); pc_in = 12'hFFF;
        cyc = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (ea != 12'h555 || done) cyc++;
        end
        chk("R9 ea held", cyc, 0);
    endtask

    task automatic t_reset_mid;
        lat = 5;
        @(negedge clk);
        instr = mk(3'd0, 1, 0, 7'h30); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R10 busy before reset", busy, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 mid reset busy", busy, 0);
        chk("R10 mid reset req", mem_req, 0);
        chk("R10 mid reset done", done, 0);
    endtask

    initial begin
        for (int i = 0; i < (1 << W); i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        t_direct;
        t_indirect;
        t_auto;
        t_outside;
        t_busy_ignore;
        t_reset_mid;
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", ntest, nfail);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            ntest++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", ntest, nfail);
            $finish;
        end
    end
endmodule